// File: doc/BRIEF.md
# Four-bit function-selectable ALU slice

A purely combinational arithmetic/logic slice that works on two 4-bit operands with active-high data. A 4-bit select code and a mode bit choose one of 32 operations. With the mode bit set, the slice applies one of the sixteen possible two-input Boolean functions to each bit pair, with no carries between bits. With the mode bit clear, it adds two select-shaped terms of the operands plus an incoming carry, using full carry lookahead inside the slice.

The carry pins use inverted sense: a low carry input means "carry applied", and a low carry output means "carry produced". Wider words are built by wiring each slice's carry output to the next slice's carry input. The slice also drives active-low group propagate and generate signals for an external lookahead unit, and an all-ones flag. After a subtract this flag shows operand equality.

Per bit i, two terms are formed: X = A | (B & S[0]) | (~B & S[1]) and Y = (A & ~B & S[2]) | (A & B & S[3]). S[0] is the least significant select bit. Select codes below are written S[3]S[2]S[1]S[0].

Top module: `alu_slice`

## Requirements
- R1: In logic mode (mode_i=1), each result bit depends only on its own A and B bits, and the carry input has no effect on the result.
- R2: In logic mode, result bit i is ~S[1] for (A,B)=(0,0), ~S[0] for (0,1), S[2] for (1,0) and S[3] for (1,1). So 0110 gives A XOR B, 1001 gives XNOR, 0011 gives all zeros, 1100 gives all ones, 1111 gives A, 1010 gives B, 0000 gives NOT A and 0001 gives NOR.
- R3: In arithmetic mode (mode_i=0) with no carry (cin_n_i=1), the result is (X + Y) mod 16. So 1001 gives A plus B, 0110 gives A minus B minus 1, 1100 gives A plus A, 0001 gives A OR B, 0100 gives A plus (A AND NOT B), and 1111 gives A minus 1.
- R4: In arithmetic mode, driving cin_n_i low adds one to the result, so 0110 with carry gives A minus B and 1111 with carry gives A.
- R5: cout_n_o is low exactly when X + Y + carry-in is 16 or more.
- R6: With code 0110 and carry applied, cout_n_o low means no borrow (A >= B), and cout_n_o high means underflow (A < B).
- R7: eq_o is high exactly when all four result bits are 1. With code 0110 in arithmetic mode and no carry, eq_o is high exactly when A equals B, and cout_n_o low with eq_o low means A > B.
- R8: prop_n_o is low exactly when every X bit is 1. gen_n_o is low exactly when X + Y is 16 or more. Neither output depends on cin_n_i.
- R9: Four slices chained by their carry pins form a correct 16-bit adder (code 1001) and subtractor (code 0110 with carry applied), including the final carry or borrow.
- R10: cout_n_o, prop_n_o and gen_n_o take the same values in logic mode as in arithmetic mode for the same operands, select code and carry input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 4 | Operand A, active high |
| b_i | input | 4 | Operand B, active high |
| sel_i | input | 4 | Function select code |
| mode_i | input | 1 | 1 = bitwise logic, 0 = arithmetic |
| cin_n_i | input | 1 | Carry input, low = carry applied |
| f_o | output | 4 | Result |
| cout_n_o | output | 1 | Carry output, low = carry produced |
| prop_n_o | output | 1 | Group propagate, active low |
| gen_n_o | output | 1 | Group generate, active low |
| eq_o | output | 1 | High when every result bit is 1 |

## Verification
The bench drives every operand pair under every select code, in both modes and with both carry values.

- The inverted carry sense is the likeliest fault. A slice that reads the carry pin as active high would be off by one in every arithmetic result.
- A slice that leaks carries into logic mode would make the XOR code depend on the carry input.
- In the subtract and compare cases at the 0/15 edges, swapping the meaning of borrow would report A greater than B as underflow.
- Chaining four slices shows whether a carry generated inside one slice reaches the next. A generate term that depended on the carry input would break the lookahead contract and show up as a group output that changes with the carry pin.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;
  localparam int unsigned SLICE_W = 4;
  localparam int unsigned SEL_W   = 4;

  // Select codes whose behaviour other logic relies on.
  localparam logic [SEL_W-1:0] SEL_ADD  = 4'b1001;
  localparam logic [SEL_W-1:0] SEL_SUB  = 4'b0110;
  localparam logic [SEL_W-1:0] SEL_DBL  = 4'b1100;
  localparam logic [SEL_W-1:0] SEL_PASS = 4'b1111;
endpackage

// File: rtl/alu_term_gen.sv
module alu_term_gen #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       sel_i,
  output logic [WIDTH-1:0] x_o,
  output logic [WIDTH-1:0] y_o
);
  // Per-bit terms: x is the OR-shaped term, y the AND-shaped term.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign x_o[i] = a_i[i] | (b_i[i] & sel_i[0]) | (~b_i[i] & sel_i[1]);
    assign y_o[i] = (a_i[i] & ~b_i[i] & sel_i[2]) | (a_i[i] & b_i[i] & sel_i[3]);
  end
endmodule

// File: rtl/alu_carry_la.sv
module alu_carry_la #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] prop_i,
  input  logic [WIDTH-1:0] gen_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] carry_o,
  output logic             cout_o,
  output logic             grp_p_o,
  output logic             grp_g_o
);
  logic [WIDTH:0] c_all;

  // Sum-of-products lookahead: each carry is formed directly from the
  // generate and propagate bits below it, never from another carry.
  always_comb begin
    for (int i = 0; i <= WIDTH; i++) begin
      logic acc;
      logic run;
      run = cin_i;
      for (int k = 0; k < i; k++) run = run & prop_i[k];
      acc = run;
      for (int j = 0; j < i; j++) begin
        run = gen_i[j];
        for (int k = j + 1; k < i; k++) run = run & prop_i[k];
        acc = acc | run;
      end
      c_all[i] = acc;
    end
  end

  // Group terms exclude the carry input entirely.
  always_comb begin
    logic run;
    grp_p_o = &prop_i;
    grp_g_o = 1'b0;
    for (int j = 0; j < WIDTH; j++) begin
      run = gen_i[j];
      for (int k = j + 1; k < WIDTH; k++) run = run & prop_i[k];
      grp_g_o = grp_g_o | run;
    end
  end

  assign carry_o = c_all[WIDTH-1:0];
  assign cout_o  = c_all[WIDTH];

  // R8 / R5: the rippled-in carry must agree with the group terms.
  always_comb begin
    if (!$isunknown({prop_i, gen_i, cin_i})) begin
      a_r8_group_consistent: assert (cout_o == (grp_g_o | (grp_p_o & cin_i)))
        else $error("carry out disagrees with group propagate/generate");
    end
  end
endmodule

// File: rtl/alu_result_mux.sv
module alu_result_mux #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic [WIDTH-1:0] carry_i,
  input  logic             logic_mode_i,
  output logic [WIDTH-1:0] f_o,
  output logic             eq_o
);
  logic [WIDTH-1:0] half;

  assign half = x_i ^ y_i;

  // Logic mode blocks every carry and inverts the half sum.
  always_comb begin
    if (logic_mode_i) f_o = ~half;
    else              f_o = half ^ carry_i;
  end

  assign eq_o = &f_o;
endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_slice_pkg::*;
#(
  parameter int unsigned WIDTH = SLICE_W
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             mode_i,
  input  logic             cin_n_i,
  output logic [WIDTH-1:0] f_o,
  output logic             cout_n_o,
  output logic             prop_n_o,
  output logic             gen_n_o,
  output logic             eq_o
);
  logic [WIDTH-1:0] x_term;
  logic [WIDTH-1:0] y_term;
  logic [WIDTH-1:0] carry;
  logic             cin;
  logic             cout;
  logic             grp_p;
  logic             grp_g;

  // Pins carry inverted sense; the core works with true carries.
  assign cin = ~cin_n_i;

  alu_term_gen #(.WIDTH(WIDTH)) u_terms (
    .a_i   (a_i),
    .b_i   (b_i),
    .sel_i (sel_i),
    .x_o   (x_term),
    .y_o   (y_term)
  );

  alu_carry_la #(.WIDTH(WIDTH)) u_carry (
    .prop_i  (x_term),
    .gen_i   (y_term),
    .cin_i   (cin),
    .carry_o (carry),
    .cout_o  (cout),
    .grp_p_o (grp_p),
    .grp_g_o (grp_g)
  );

  alu_result_mux #(.WIDTH(WIDTH)) u_result (
    .x_i          (x_term),
    .y_i          (y_term),
    .carry_i      (carry),
    .logic_mode_i (mode_i),
    .f_o          (f_o),
    .eq_o         (eq_o)
  );

  assign cout_n_o = ~cout;
  assign prop_n_o = ~grp_p;
  assign gen_n_o  = ~grp_g;

  // Assertions check the assembled slice against the operand bits directly.
  always_comb begin
    logic [WIDTH:0]   sum_chk;
    logic [WIDTH-1:0] tt_chk;
    if (!$isunknown({a_i, b_i, sel_i, mode_i, cin_n_i})) begin
      for (int i = 0; i < WIDTH; i++) begin
        case ({a_i[i], b_i[i]})
          2'b00:   tt_chk[i] = ~sel_i[1];
          2'b01:   tt_chk[i] = ~sel_i[0];
          2'b10:   tt_chk[i] = sel_i[2];
          default: tt_chk[i] = sel_i[3];
        endcase
      end
      // R1 / R2: logic mode is a per-bit truth table chosen by the select code.
      if (mode_i) begin
        a_r2_logic_truth: assert (f_o == tt_chk)
          else $error("logic-mode result off the select truth table");
      end
      // R3 / R4: arithmetic mode is the sum of both terms plus carry.
      sum_chk = {1'b0, x_term} + {1'b0, y_term} + {{WIDTH{1'b0}}, cin};
      if (!mode_i) begin
        a_r3_arith_sum: assert (f_o == sum_chk[WIDTH-1:0])
          else $error("arithmetic result differs from term sum");
      end
      // R5: a group generate always produces a carry out.
      if (!gen_n_o) begin
        a_r5_gen_forces_carry: assert (!cout_n_o)
          else $error("group generate without carry out");
      end
      // R5: full propagate without generate passes the carry pin through.
      if (!prop_n_o && gen_n_o) begin
        a_r5_prop_passes: assert (cout_n_o == cin_n_i)
          else $error("propagating group failed to pass carry");
      end
      // R7: subtract with no carry flags operand equality.
      if (!mode_i && sel_i == SEL_SUB && cin_n_i) begin
        a_r7_sub_equal: assert (eq_o == (a_i == b_i))
          else $error("equality flag wrong after subtract");
      end
    end
  end
endmodule

// File: tb/test_alu_slice.sv
`timescale 1ns/1ps
module test_alu_slice;
  localparam int W = 4;

  logic clk;
  int   n_checks;
  int   n_fail;
  bit   done;

  logic [W-1:0] a, b, sel;
  logic         mode, cin_n;
  logic [W-1:0] f;
  logic         cout_n, prop_n, gen_n, eq;

  alu_slice #(.WIDTH(W)) i_alu_slice (
    .a_i(a), .b_i(b), .sel_i(sel), .mode_i(mode), .cin_n_i(cin_n),
    .f_o(f), .cout_n_o(cout_n), .prop_n_o(prop_n), .gen_n_o(gen_n), .eq_o(eq)
  );

  // 16-bit chain of four slices rippled through the carry pins (R9).
  logic [15:0] ch_a, ch_b, ch_f;
  logic [3:0]  ch_sel;
  logic        ch_mode, ch_cin_n;
  logic [4:0]  ch_c;
  logic [3:0]  ch_p, ch_g, ch_eq;
  assign ch_c[0] = ch_cin_n;

  for (genvar k = 0; k < 4; k++) begin : g_chain
    alu_slice #(.WIDTH(4)) i_alu_slice_chain (
      .a_i(ch_a[4*k +: 4]), .b_i(ch_b[4*k +: 4]), .sel_i(ch_sel),
      .mode_i(ch_mode), .cin_n_i(ch_c[k]),
      .f_o(ch_f[4*k +: 4]), .cout_n_o(ch_c[k+1]),
      .prop_n_o(ch_p[k]), .gen_n_o(ch_g[k]), .eq_o(ch_eq[k])
    );
  end

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input bit ok, input int act, input int exp_v);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic drive(input logic [3:0] ta, input logic [3:0] tb_, input logic [3:0] ts,
                       input logic tm, input logic tc);
    a = ta; b = tb_; sel = ts; mode = tm; cin_n = tc;
    #1;
  endtask

  // Reference models taken from the requirement text.
  function automatic logic [3:0] logic_ref(input logic [3:0] ra, input logic [3:0] rb,
                                           input logic [3:0] rs);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) begin
      case ({ra[i], rb[i]})
        2'b00:   r[i] = ~rs[1];
        2'b01:   r[i] = ~rs[0];
        2'b10:   r[i] = rs[2];
        default: r[i] = rs[3];
      endcase
    end
    return r;
  endfunction

  function automatic int term_x(input logic [3:0] ra, input logic [3:0] rb, input logic [3:0] rs);
    return int'((ra | (rb & {4{rs[0]}}) | (~rb & {4{rs[1]}})) & 4'hF);
  endfunction

  function automatic int term_y(input logic [3:0] ra, input logic [3:0] rb, input logic [3:0] rs);
    return int'(((ra & ~rb & {4{rs[2]}}) | (ra & rb & {4{rs[3]}})) & 4'hF);
  endfunction

  task automatic t_idle();
    drive(4'h0, 4'h0, 4'h0, 1'b0, 1'b1);
    chk("R3 idle result", f == 4'h0, int'(f), 0);
    chk("R5 idle carry", cout_n == 1'b1, int'(cout_n), 1);
  endtask

  task automatic t_logic_exhaustive();
    for (int s = 0; s < 16; s++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++)
          for (int c = 0; c < 2; c++) begin
            logic [3:0] e;
            e = logic_ref(4'(x), 4'(y), 4'(s));
            drive(4'(x), 4'(y), 4'(s), 1'b1, 1'(c));
            chk("R1/R2 logic table", f == e, int'(f), int'(e));
          end
  endtask

  task automatic t_logic_named();
    drive(4'hC, 4'hA, 4'b0110, 1'b1, 1'b0);
    chk("R2 xor", f == 4'h6, int'(f), 6);
    drive(4'hC, 4'hA, 4'b1001, 1'b1, 1'b1);
    chk("R2 xnor", f == 4'h9, int'(f), 9);
    drive(4'hC, 4'hA, 4'b0011, 1'b1, 1'b0);
    chk("R2 zeros", f == 4'h0, int'(f), 0);
    drive(4'hC, 4'hA, 4'b1100, 1'b1, 1'b1);
    chk("R2 ones", f == 4'hF, int'(f), 15);
    drive(4'hC, 4'hA, 4'b1111, 1'b1, 1'b1);
    chk("R2 pass A", f == 4'hC, int'(f), 12);
    drive(4'hC, 4'hA, 4'b1010, 1'b1, 1'b1);
    chk("R2 pass B", f == 4'hA, int'(f), 10);
    drive(4'hC, 4'hA, 4'b0000, 1'b1, 1'b1);
    chk("R2 not A", f == 4'h3, int'(f), 3);
    drive(4'hC, 4'hA, 4'b0001, 1'b1, 1'b1);
    chk("R2 nor", f == 4'h1, int'(f), 1);
    // R1: one operand bit changed touches only its own result bit.
    drive(4'h0, 4'h0, 4'b0110, 1'b1, 1'b1);
    drive(4'h4, 4'h0, 4'b0110, 1'b1, 1'b1);
    chk("R1 bit isolation", f == 4'h4, int'(f), 4);
  endtask

  task automatic t_arith_named();
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++)
        for (int c = 0; c < 2; c++) begin
          int ci;
          ci = (c == 0) ? 1 : 0;
          drive(4'(x), 4'(y), 4'b1001, 1'b0, 1'(c));
          chk("R3/R4 add", int'(f) == ((x + y + ci) & 15), int'(f), (x + y + ci) & 15);
          drive(4'(x), 4'(y), 4'b0110, 1'b0, 1'(c));
          chk("R3/R4 sub", int'(f) == ((x - y - 1 + ci) & 15), int'(f), (x - y - 1 + ci) & 15);
          drive(4'(x), 4'(y), 4'b1100, 1'b0, 1'(c));
          chk("R3/R4 double", int'(f) == ((2 * x + ci) & 15), int'(f), (2 * x + ci) & 15);
          drive(4'(x), 4'(y), 4'b0001, 1'b0, 1'(c));
          chk("R3/R4 or", int'(f) == (((x | y) + ci) & 15), int'(f), ((x | y) + ci) & 15);
          drive(4'(x), 4'(y), 4'b0100, 1'b0, 1'(c));
          chk("R3/R4 a plus a&~b", int'(f) == ((x + (x & ~y & 15) + ci) & 15),
              int'(f), (x + (x & ~y & 15) + ci) & 15);
          drive(4'(x), 4'(y), 4'b1111, 1'b0, 1'(c));
          chk("R3/R4 a minus 1", int'(f) == ((x - 1 + ci) & 15), int'(f), (x - 1 + ci) & 15);
        end
  endtask

  task automatic t_arith_all_codes();
    for (int s = 0; s < 16; s++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++)
          for (int c = 0; c < 2; c++) begin
            int tx, ty, ci, tot;
            tx = term_x(4'(x), 4'(y), 4'(s));
            ty = term_y(4'(x), 4'(y), 4'(s));
            ci = (c == 0) ? 1 : 0;
            tot = tx + ty + ci;
            drive(4'(x), 4'(y), 4'(s), 1'b0, 1'(c));
            chk("R3 term sum", int'(f) == (tot & 15), int'(f), tot & 15);
            chk("R5 carry out", cout_n == (tot < 16), int'(cout_n), int'(tot < 16));
            chk("R7 all-ones flag", eq == (f == 4'hF), int'(eq), int'(f == 4'hF));
            chk("R8 propagate", prop_n == (tx != 15), int'(prop_n), int'(tx != 15));
            chk("R8 generate", gen_n == ((tx + ty) < 16), int'(gen_n), int'((tx + ty) < 16));
          end
  endtask

  task automatic t_compare();
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++) begin
        drive(4'(x), 4'(y), 4'b0110, 1'b0, 1'b0);
        chk("R6 borrow sense", cout_n == (x < y), int'(cout_n), int'(x < y));
        drive(4'(x), 4'(y), 4'b0110, 1'b0, 1'b1);
        chk("R7 equality", eq == (x == y), int'(eq), int'(x == y));
        chk("R7 greater", (!cout_n && !eq) == (x > y), int'(!cout_n && !eq), int'(x > y));
      end
  endtask

  task automatic t_group_cin_mode();
    for (int s = 0; s < 16; s++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++) begin
          logic p0, g0, c0, c1;
          drive(4'(x), 4'(y), 4'(s), 1'b0, 1'b1);
          p0 = prop_n; g0 = gen_n; c0 = cout_n;
          drive(4'(x), 4'(y), 4'(s), 1'b0, 1'b0);
          c1 = cout_n;
          chk("R8 P/G ignore carry pin", {prop_n, gen_n} == {p0, g0},
              int'({prop_n, gen_n}), int'({p0, g0}));
          drive(4'(x), 4'(y), 4'(s), 1'b1, 1'b0);
          chk("R10 carry in logic mode", cout_n == c1, int'(cout_n), int'(c1));
          drive(4'(x), 4'(y), 4'(s), 1'b1, 1'b1);
          chk("R10 P/G/C in logic mode", {prop_n, gen_n, cout_n} == {p0, g0, c0},
              int'({prop_n, gen_n, cout_n}), int'({p0, g0, c0}));
        end
  endtask

  task automatic t_cascade();
    logic [15:0] va [0:7];
    logic [15:0] vb [0:7];
    logic [31:0] lcg;
    va[0] = 16'hFFFF; vb[0] = 16'h0001;
    va[1] = 16'h8000; vb[1] = 16'h8001;
    va[2] = 16'h0000; vb[2] = 16'h0000;
    va[3] = 16'h1234; vb[3] = 16'h1234;
    va[4] = 16'h00FF; vb[4] = 16'h0F01;
    lcg = 32'h1F2E3D4C;
    for (int v = 5; v < 8; v++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      va[v] = lcg[31:16];
      lcg = lcg * 32'd1103515245 + 32'd12345;
      vb[v] = lcg[31:16];
    end
    for (int v = 0; v < 8; v++) begin
      int sa, sb, tot, dif;
      sa = int'(va[v]); sb = int'(vb[v]);
      ch_a = va[v]; ch_b = vb[v]; ch_mode = 1'b0;
      ch_sel = 4'b1001; ch_cin_n = 1'b1; #1;
      tot = sa + sb;
      chk("R9 chain add", int'(ch_f) == (tot & 16'hFFFF), int'(ch_f), tot & 16'hFFFF);
      chk("R9 chain add carry", ch_c[4] == (tot < 65536), int'(ch_c[4]), int'(tot < 65536));
      ch_cin_n = 1'b0; #1;
      chk("R9 chain add+1", int'(ch_f) == ((tot + 1) & 16'hFFFF), int'(ch_f), (tot + 1) & 16'hFFFF);
      ch_sel = 4'b0110; ch_cin_n = 1'b0; #1;
      dif = sa - sb;
      chk("R9 chain sub", int'(ch_f) == (dif & 16'hFFFF), int'(ch_f), dif & 16'hFFFF);
      chk("R9 chain borrow", ch_c[4] == (sa < sb), int'(ch_c[4]), int'(sa < sb));
      ch_cin_n = 1'b1; #1;
      chk("R7 chain equality", (&ch_eq) == (sa == sb), int'(&ch_eq), int'(sa == sb));
    end
  endtask

  initial begin
    n_checks = 0; n_fail = 0; done = 1'b0;
    a = '0; b = '0; sel = '0; mode = 1'b0; cin_n = 1'b1;
    ch_a = '0; ch_b = '0; ch_sel = '0; ch_mode = 1'b0; ch_cin_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    t_idle();
    t_logic_named();
    t_logic_exhaustive();
    t_arith_named();
    t_arith_all_codes();
    t_compare();
    t_group_cin_mode();
    t_cascade();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule